// File: doc/BRIEF.md
# Lockable SMI Enable Register

This block holds two control registers that live in different address spaces. The first is a 16-bit power-management control word in configuration space. Configuration space is reached through a dword-aligned 32-bit write port with four byte enables. The second is a 32-bit SMI enable register in I/O space, reached through its own 32-bit byte-enabled write port. Both registers are always visible on read-back outputs.

Every write to the SMI enable register passes through a per-bit write mask. After reset the mask is all ones. Firmware can set a lock bit in the control word. From the next cycle on, the global SMI enable bit of the I/O register is frozen, and the lock bit itself also becomes read-only. Only reset releases either one. The block is meant to sit beside a configuration decoder and an I/O decoder. It takes their write strobes and presents the stored values back to them.

Top module: `smi_lock_regs`

## Requirements
- R1: After reset the control word reads 0x0000, the lock output is 0, and the SMI enable register reads its reset default. The default has bit 5 (APM-command enable) set when parameter SMM_DEFAULT is 1, and is zero otherwise.
- R2: An I/O write replaces exactly the SMI enable bytes whose byte enable is 1 (ioBe[k] covers bits 8k+7..8k), limited to bits whose write-mask bit is 1. All other bits keep their value, and no bit changes in a cycle without an I/O write.
- R3: While unlocked, every SMI enable bit, including bit 0, is writable.
- R4: A configuration write to dword address 0xA0 updates the control word from data bits 15..0: cfgBe[0] covers bits 7..0 and cfgBe[1] covers bits 15..8. Writes to any other address, and to byte lanes 2 and 3, leave the control word unchanged.
- R5: Writing 1 to control-word bit 4 (the lock bit) raises lockedOut in the next cycle. From then on, bit 0 (global SMI enable) of the SMI enable register keeps its value through every I/O write.
- R6: Once locked, no configuration write clears the lock bit or lockedOut.
- R7: When an I/O write lands in the same cycle as the configuration write that sets the lock, it uses the mask that was in force before that cycle, so bit 0 still takes the written value.
- R8: While locked, the control-word bits other than the lock bit stay writable, and SMI enable bits 31..1 stay writable.
- R9: Reset clears the lock and reopens bit 0 of the SMI enable register for writing.
- R10: The lock is re-evaluated only on a configuration write with at least one byte enable set whose dword lies inside the 8-byte window starting at 0xA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte address; bits 1..0 ignored |
| cfgBe | input | 4 | Configuration byte enables |
| cfgWrData | input | 32 | Configuration write data |
| ioWrEn | input | 1 | SMI enable register write strobe |
| ioBe | input | 4 | I/O byte enables |
| ioWrData | input | 32 | I/O write data |
| pmconWord | output | 16 | Current control word |
| smiEnWord | output | 32 | Current SMI enable register |
| lockedOut | output | 1 | Lock state; bit 0 of the SMI enable register is frozen while high |

## Verification
The bench builds the block with its default parameters: SMM_DEFAULT set, the control word at 0xA0, the lock in bit 4, and the global enable in bit 0. With SMM_DEFAULT set, the non-zero reset default of the SMI enable register becomes visible. The fixed offsets let the bench aim writes inside, just beside and outside the 8-byte lock window. The sequence reaches the lock-set cycle with a simultaneous I/O write, attempts to unlock, partial byte-enable writes on both ports, and a second reset that reopens the frozen bit.

// File: rtl/smi_lock_pkg.sv
package smi_lock_pkg;
  parameter int SMI_W    = 32;
  parameter int PM_W     = 16;
  parameter int SMI_BYTES = SMI_W / 8;
  parameter int PM_BYTES  = PM_W / 8;

  typedef struct packed {
    logic [PM_BYTES-1:0]  pmconBe;   // control-word byte lanes to write
    logic                 lockEval;  // re-evaluate lock after this write
    logic [SMI_BYTES-1:0] smiBe;     // SMI enable byte lanes to write
  } ctrlStrobes_t;
endpackage

// File: rtl/smi_lock_ctrl.sv
module smi_lock_ctrl
  import smi_lock_pkg::*;
#(
  parameter int          CFG_AW    = 8,
  parameter logic [7:0]  PMCON_OFS = 8'hA0,
  parameter int          LOCK_SPAN = 8
) (
  input  logic                 cfgWrEn,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [3:0]           cfgBe,
  input  logic                 ioWrEn,
  input  logic [SMI_BYTES-1:0] ioBe,
  output ctrlStrobes_t         strobes
);
  localparam int DW_AW   = CFG_AW - 2;
  localparam int PM_DW   = int'(PMCON_OFS) / 4;
  localparam int SPAN_DW = LOCK_SPAN / 4;

  logic [DW_AW-1:0] dwIdx;
  logic             hitPmcon;
  logic             inWindow;

  assign dwIdx    = cfgAddr[CFG_AW-1:2];
  assign hitPmcon = (int'(dwIdx) == PM_DW);
  assign inWindow = (int'(dwIdx) >= PM_DW) && (int'(dwIdx) < PM_DW + SPAN_DW);

  always_comb begin
    strobes          = '0;
    strobes.pmconBe  = (cfgWrEn && hitPmcon) ? cfgBe[PM_BYTES-1:0] : '0;
    strobes.lockEval = cfgWrEn && inWindow && (|cfgBe);
    strobes.smiBe    = ioWrEn ? ioBe : '0;
  end
endmodule

// File: rtl/smi_lock_dp.sv
module smi_lock_dp
  import smi_lock_pkg::*;
#(
  parameter int LOCK_POS    = 4,
  parameter int GBL_POS     = 0,
  parameter int APMC_POS    = 5,
  parameter bit SMM_DEFAULT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [31:0]      cfgWrData,
  input  logic [SMI_W-1:0] ioWrData,
  output logic [PM_W-1:0]  pmconQ,
  output logic [SMI_W-1:0] smiEnQ,
  output logic             lockedQ
);
  localparam logic [SMI_W-1:0] SMI_RST  = SMM_DEFAULT ? (SMI_W'(1) << APMC_POS) : '0;
  localparam logic [SMI_W-1:0] GBL_BIT  = SMI_W'(1) << GBL_POS;
  localparam logic [PM_W-1:0]  LOCK_BIT = PM_W'(1) << LOCK_POS;

  logic [PM_W-1:0]  pmByteMask, pmWmask, pmNext;
  logic [SMI_W-1:0] smiByteMask, smiWmask, smiNext;
  logic             lockNext;

  for (genvar b = 0; b < PM_BYTES; b++) begin : gPmLane
    assign pmByteMask[8*b +: 8] = {8{strobes.pmconBe[b]}};
  end
  for (genvar b = 0; b < SMI_BYTES; b++) begin : gSmiLane
    assign smiByteMask[8*b +: 8] = {8{strobes.smiBe[b]}};
  end

  always_comb begin
    pmWmask  = lockedQ ? ~LOCK_BIT : '1;
    smiWmask = lockedQ ? ~GBL_BIT  : '1;
    pmNext   = (pmconQ & ~(pmWmask & pmByteMask)) |
               (cfgWrData[PM_W-1:0] & pmWmask & pmByteMask);
    smiNext  = (smiEnQ & ~(smiWmask & smiByteMask)) |
               (ioWrData & smiWmask & smiByteMask);
    lockNext = lockedQ | (strobes.lockEval & pmNext[LOCK_POS]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmconQ  <= '0;
      smiEnQ  <= SMI_RST;
      lockedQ <= 1'b0;
    end else begin
      pmconQ  <= pmNext;
      smiEnQ  <= smiNext;
      lockedQ <= lockNext;
    end
  end
endmodule

// File: rtl/smi_lock_regs.sv
module smi_lock_regs
  import smi_lock_pkg::*;
#(
  parameter int         CFG_AW      = 8,
  parameter logic [7:0] PMCON_OFS   = 8'hA0,
  parameter int         LOCK_SPAN   = 8,
  parameter int         LOCK_POS    = 4,
  parameter int         GBL_POS     = 0,
  parameter int         APMC_POS    = 5,
  parameter bit         SMM_DEFAULT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [3:0]        cfgBe,
  input  logic [31:0]       cfgWrData,
  input  logic              ioWrEn,
  input  logic [3:0]        ioBe,
  input  logic [31:0]       ioWrData,
  output logic [15:0]       pmconWord,
  output logic [31:0]       smiEnWord,
  output logic              lockedOut
);
  ctrlStrobes_t strobes;

  smi_lock_ctrl #(
    .CFG_AW(CFG_AW), .PMCON_OFS(PMCON_OFS), .LOCK_SPAN(LOCK_SPAN)
  ) uCtrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgBe(cfgBe),
    .ioWrEn(ioWrEn), .ioBe(ioBe), .strobes(strobes)
  );

  smi_lock_dp #(
    .LOCK_POS(LOCK_POS), .GBL_POS(GBL_POS), .APMC_POS(APMC_POS),
    .SMM_DEFAULT(SMM_DEFAULT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgWrData(cfgWrData), .ioWrData(ioWrData),
    .pmconQ(pmconWord), .smiEnQ(smiEnWord), .lockedQ(lockedOut)
  );
endmodule

// File: rtl/smi_lock_checker.sv
module smi_lock_checker #(
  parameter int LOCK_POS = 4,
  parameter int GBL_POS  = 0
) (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic        ioWrEn,
  input logic [15:0] pmconWord,
  input logic [31:0] smiEnWord,
  input logic        lockedOut
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |=> lockedOut); // R6
  AST_LOCKBIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |-> pmconWord[LOCK_POS]); // R6
  AST_LOCK_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    pmconWord[LOCK_POS] |-> lockedOut); // R5
  AST_GBL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |=> (smiEnWord[GBL_POS] == $past(smiEnWord[GBL_POS]))); // R5
  AST_SMI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrEn |=> $stable(smiEnWord)); // R2
  AST_PMCON_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(pmconWord)); // R4
  AST_NO_LOCK_WITHOUT_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !lockedOut) |=> !lockedOut); // R10
endmodule

bind smi_lock_regs smi_lock_checker #(
  .LOCK_POS(LOCK_POS), .GBL_POS(GBL_POS)
) uChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .ioWrEn(ioWrEn),
  .pmconWord(pmconWord), .smiEnWord(smiEnWord), .lockedOut(lockedOut)
);

// File: tb/smi_lock_regs_test.sv
`timescale 1ns/1ps
module smi_lock_regs_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [7:0]  cfgAddr;
  logic [3:0]  cfgBe;
  logic [31:0] cfgWrData;
  logic        ioWrEn;
  logic [3:0]  ioBe;
  logic [31:0] ioWrData;
  logic [15:0] pmconWord;
  logic [31:0] smiEnWord;
  logic        lockedOut;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [15:0] mPm;
  logic [31:0] mSmi;
  logic        mLock;

  always #10 clk = ~clk;

  smi_lock_regs uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgBe(cfgBe), .cfgWrData(cfgWrData), .ioWrEn(ioWrEn), .ioBe(ioBe),
    .ioWrData(ioWrData), .pmconWord(pmconWord), .smiEnWord(smiEnWord),
    .lockedOut(lockedOut)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // advance model by one clock edge using the currently driven inputs
  task automatic modelEdge();
    logic [31:0] nSmi;
    logic [15:0] nPm;
    logic        nLock;
    int          dw;
    if (!rstN) begin
      mPm = 16'h0; mSmi = 32'h0000_0020; mLock = 1'b0;
      return;
    end
    nSmi = mSmi; nPm = mPm; nLock = mLock;
    if (ioWrEn) begin
      for (int i = 0; i < 32; i++) begin
        if (ioBe[i/8] && !(mLock && i == 0)) nSmi[i] = ioWrData[i];
      end
    end
    if (cfgWrEn) begin
      dw = int'(cfgAddr) / 4;
      if (dw == 8'hA0 / 4) begin
        for (int i = 0; i < 16; i++) begin
          if (cfgBe[i/8] && !(mLock && i == 4)) nPm[i] = cfgWrData[i];
        end
      end
      if ((dw == 8'hA0 / 4 || dw == 8'hA4 / 4) && cfgBe != 4'b0 && nPm[4]) nLock = 1'b1;
    end
    mSmi = nSmi; mPm = nPm; mLock = nLock;
  endtask

  task automatic step(string req);
    @(posedge clk);
    modelEdge();
    #5;
    check(req, "pmconWord", {16'h0, pmconWord}, {16'h0, mPm});
    check(req, "smiEnWord", smiEnWord, mSmi);
    check(req, "lockedOut", {31'h0, lockedOut}, {31'h0, mLock});
  endtask

  task automatic idle();
    @(negedge clk);
    cfgWrEn = 0; ioWrEn = 0; cfgBe = 0; ioBe = 0;
    cfgAddr = 0; cfgWrData = 0; ioWrData = 0;
  endtask

  task automatic ioWr(logic [3:0] be, logic [31:0] d, string req);
    idle();
    ioWrEn = 1; ioBe = be; ioWrData = d;
    step(req);
  endtask

  task automatic cfgWr(logic [7:0] a, logic [3:0] be, logic [31:0] d, string req);
    idle();
    cfgWrEn = 1; cfgAddr = a; cfgBe = be; cfgWrData = d;
    step(req);
  endtask

  task automatic doReset(string req);
    idle();
    rstN = 0;
    step(req);
    step(req);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; cfgWrEn = 0; ioWrEn = 0; cfgBe = 0; ioBe = 0;
    cfgAddr = 0; cfgWrData = 0; ioWrData = 0;
    mPm = 0; mSmi = 32'h20; mLock = 0;
    doReset("R1");
    check("R1", "smi default", smiEnWord, 32'h0000_0020);
    check("R1", "pmcon default", {16'h0, pmconWord}, 32'h0);

    ioWr(4'b1111, 32'hFFFF_FFFF, "R3");
    ioWr(4'b0001, 32'h0000_0000, "R3");
    ioWr(4'b0110, 32'h1234_5678, "R2");
    idle(); step("R2");                       // no write: hold
    ioWr(4'b0000, 32'hFFFF_FFFF, "R2");

    cfgWr(8'hA0, 4'b0011, 32'h0000_00E8, "R4");
    cfgWr(8'hA8, 4'b1111, 32'hFFFF_FFFF, "R4");
    cfgWr(8'h9C, 4'b1111, 32'hFFFF_FFFF, "R4");
    cfgWr(8'hA0, 4'b0010, 32'h0000_AB00, "R4");
    cfgWr(8'hA0, 4'b1100, 32'hFFFF_FFFF, "R4");
    cfgWr(8'hA0, 4'b0000, 32'h0000_0010, "R10");
    cfgWr(8'hA4, 4'b1111, 32'hFFFF_FFFF, "R10");

    // lock set together with an I/O write that sets bit 0
    idle();
    cfgWrEn = 1; cfgAddr = 8'hA0; cfgBe = 4'b0001; cfgWrData = 32'h0000_0010;
    ioWrEn = 1; ioBe = 4'b0001; ioWrData = 32'h0000_0001;
    step("R7");
    check("R7", "bit0 taken", {31'h0, smiEnWord[0]}, 32'h1);
    check("R5", "locked", {31'h0, lockedOut}, 32'h1);

    ioWr(4'b1111, 32'h0000_0000, "R5");
    check("R5", "bit0 frozen", {31'h0, smiEnWord[0]}, 32'h1);
    ioWr(4'b1111, 32'hFFFF_FFFE, "R8");
    cfgWr(8'hA0, 4'b0011, 32'h0000_0000, "R6");
    check("R6", "lock bit", {31'h0, pmconWord[4]}, 32'h1);
    cfgWr(8'hA0, 4'b0001, 32'h0000_000F, "R8");
    cfgWr(8'hA4, 4'b1111, 32'h0000_0000, "R6");

    doReset("R9");
    ioWr(4'b1111, 32'h0000_0000, "R9");
    check("R9", "bit0 reopened", {31'h0, smiEnWord[0]}, 32'h0);
    idle(); step("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule